// File: doc/BRIEF.md
# Debug Abstract Command Sequencer

This block sits between a debugger-facing register port and one processor hart. The debugger writes a 32-bit command word. The block decodes the command, checks that it is supported, and then issues one register-access operation to the hart over a valid/ready request channel. It waits for a single response beat and folds the result back into a small bank of argument words and a sticky error field.

A register read moves a hart register into argument word 0. A register write presents argument word 0 to the hart. Errors stay latched until the debugger clears them bit by bit. While an error is latched, further commands are refused without any notice. A debugger can therefore stream a batch of commands and inspect the outcome once at the end. An auto-execute mask lets an access to a chosen argument word or program-buffer slot re-issue the stored command, which makes burst transfers cheap.

The hart request follows valid/ready rules. `hart_req_valid` stays high, with every operand stable, until the cycle in which `hart_req_ready` is sampled high. After that the block waits for `hart_rsp_valid`, which it always accepts, and it never issues a second request before that response arrives.

Top module: `dbg_cmd_seq`

## Requirements
- R1: After the active-low reset, busy is 0, the error field is 0, every argument word is 0, the auto-execute mask is 0 and no hart request is raised.
- R2: An accepted write to the command register (address 0x17) reads back busy = 1 from the next cycle. Busy stays 1 until the cycle after the hart response, and `hart_req_valid` with its operands holds until `hart_req_ready`.
- R3: While busy, a command write or any read or write of an argument word sets the error field to 1 if it was 0. The argument word is left unchanged.
- R4: While the error field is non-zero, a command write, or an access that would trigger auto-execute, starts nothing: no hart request is raised and busy stays 0.
- R5: Writing the status register (address 0x16) with bit 8+k set clears bit k of the error field. No other event clears a non-zero error field.
- R6: Command word fields are type in bits 31:24, size in bits 22:20, postexec in bit 18, transfer in bit 17, write in bit 16 and register number in bits 15:0. They are presented unchanged on the hart operand pins.
- R7: A command type other than 0, or a size of 0 or 1, sets error 2 and raises no hart request.
- R8: A size above parameter MAX_SIZE (default 3) sets error 2 and raises no hart request.
- R9: On a response with code 0 and transfer = 1, write = 0 loads `hart_rsp_data` into argument word 0. Argument word 0 is always driven on `hart_arg`.
- R10: Response code 1 (exception) sets error 3, code 2 (wrong run/halt state) sets error 4 and code 3 (other) sets error 7. Busy clears in each case.
- R11: A status read returns busy in bit 12, the error field in bits 10:8, DATA_N in bits 3:0 and PROG_N in bits 28:24, with all other bits 0. Argument word i sits at address 0x04+i, the mask at 0x18 and program-buffer slot j at 0x20+j.
- R12: Mask bit i (i < DATA_N) marks argument word i and mask bit 16+j (j < PROG_N) marks program-buffer slot j. A read or write of a marked word, while idle and error-free, re-issues the stored command. Unmarked words do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low module reset |
| reg_addr | input | 7 | Register port word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| hart_req_valid | output | 1 | Hart operation request valid |
| hart_req_ready | input | 1 | Hart accepts request |
| hart_regno | output | 16 | Register number to access |
| hart_size | output | 3 | Access size code |
| hart_postexec | output | 1 | Run program buffer after transfer |
| hart_transfer | output | 1 | Perform the register transfer |
| hart_write | output | 1 | 1: write hart register from hart_arg |
| hart_arg | output | 32 | Argument word 0 |
| hart_rsp_valid | input | 1 | Hart response beat |
| hart_rsp_code | input | 2 | 0 ok, 1 exception, 2 wrong state, 3 other |
| hart_rsp_data | input | 32 | Register value for read transfers |

## Verification
Read data is combinational, so each read is sampled inside the cycle its strobe is high. Every register write takes effect at one edge. Busy, error and mask are therefore checked on a read issued in the cycle after the write edge. A command write raises `hart_req_valid` one cycle after its edge, and a response updates busy, error and argument word 0 at the edge that samples it. The bench waits for busy to drop by polling status before it compares argument words or errors. The stimulus in each refusal and conflict case lands in the one-cycle window where the design decides, and the effect is read back through the register port before the next stimulus.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
  localparam logic [6:0] ADDR_DATA0 = 7'h04;
  localparam logic [6:0] ADDR_STAT  = 7'h16;
  localparam logic [6:0] ADDR_CMD   = 7'h17;
  localparam logic [6:0] ADDR_AUTO  = 7'h18;
  localparam logic [6:0] ADDR_PBUF0 = 7'h20;

  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_BUSY  = 3'd1;
  localparam logic [2:0] ERR_UNSUP = 3'd2;
  localparam logic [2:0] ERR_EXC   = 3'd3;
  localparam logic [2:0] ERR_STATE = 3'd4;
  localparam logic [2:0] ERR_OTHER = 3'd7;

  typedef struct packed {
    logic [15:0] regno;
    logic [2:0]  size;
    logic        postexec;
    logic        transfer;
    logic        write;
  } hart_op_t;
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_cmd_pkg::*;
#(
  parameter int MAX_SIZE = 3
) (
  input  logic [31:0] cmd,
  output logic        supported,
  output hart_op_t    op
);
  logic [7:0] kind;
  logic       unused_rsv;

  assign kind        = cmd[31:24];
  assign unused_rsv  = cmd[23] ^ cmd[19];
  assign op.regno    = cmd[15:0];
  assign op.size     = cmd[22:20];
  assign op.postexec = cmd[18];
  assign op.transfer = cmd[17];
  assign op.write    = cmd[16];

  always_comb begin
    supported = (kind == 8'd0) && (op.size >= 3'd2) &&
                (int'(op.size) <= MAX_SIZE);
  end
endmodule

// File: rtl/dbg_cmd_exec.sv
module dbg_cmd_exec
  import dbg_cmd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     launch,
  input  hart_op_t op_in,
  output logic     busy,
  output logic     req_valid,
  input  logic     req_ready,
  output hart_op_t op_out,
  input  logic     rsp_valid,
  output logic     done
);
  typedef enum logic [1:0] {EX_IDLE, EX_REQ, EX_WAIT} ex_state_e;
  ex_state_e state_q;
  hart_op_t  op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EX_IDLE;
      op_q    <= '0;
    end else begin
      case (state_q)
        EX_IDLE: if (launch) begin
          state_q <= EX_REQ;
          op_q    <= op_in;
        end
        EX_REQ:  if (req_ready) state_q <= EX_WAIT;
        EX_WAIT: if (rsp_valid) state_q <= EX_IDLE;
        default: state_q <= EX_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != EX_IDLE);
  assign req_valid = (state_q == EX_REQ);
  assign op_out    = op_q;
  assign done      = (state_q == EX_WAIT) && rsp_valid;

  // R2: request and operands hold until accepted
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(op_out));
  // R2: busy only drops after a response
  a_r2_busy_until_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rsp_valid |=> busy);
  // R2: one request per launch
  a_r2_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
  import dbg_cmd_pkg::*;
#(
  parameter int DATA_N   = 2,
  parameter int PROG_N   = 8,
  parameter int MAX_SIZE = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        hart_req_valid,
  input  logic        hart_req_ready,
  output logic [15:0] hart_regno,
  output logic [2:0]  hart_size,
  output logic        hart_postexec,
  output logic        hart_transfer,
  output logic        hart_write,
  output logic [31:0] hart_arg,
  input  logic        hart_rsp_valid,
  input  logic [1:0]  hart_rsp_code,
  input  logic [31:0] hart_rsp_data
);
  localparam int PBUF_LSB = 16;

  function automatic logic [31:0] mask_valid_bits();
    logic [31:0] m = '0;
    for (int i = 0; i < DATA_N; i++) m[i] = 1'b1;
    for (int j = 0; j < PROG_N; j++) m[PBUF_LSB + j] = 1'b1;
    return m;
  endfunction
  localparam logic [31:0] MASK_VALID = mask_valid_bits();

  logic [31:0] data_q [DATA_N];
  logic [31:0] cmd_q;
  logic [31:0] mask_q;
  logic [2:0]  err_q;

  logic [DATA_N-1:0] data_sel;
  logic [PROG_N-1:0] pbuf_sel;
  logic access, is_cmd, is_stat, is_auto, data_hit, auto_hit;

  for (genvar i = 0; i < DATA_N; i++) begin : g_dsel
    assign data_sel[i] = (reg_addr == ADDR_DATA0 + 7'(i));
  end
  for (genvar j = 0; j < PROG_N; j++) begin : g_psel
    assign pbuf_sel[j] = (reg_addr == ADDR_PBUF0 + 7'(j));
  end

  assign access   = reg_wr || reg_rd;
  assign is_cmd   = (reg_addr == ADDR_CMD);
  assign is_stat  = (reg_addr == ADDR_STAT);
  assign is_auto  = (reg_addr == ADDR_AUTO);
  assign data_hit = |data_sel;
  assign auto_hit = access && (|(data_sel & mask_q[DATA_N-1:0]) ||
                               |(pbuf_sel & mask_q[PBUF_LSB +: PROG_N]));

  // decode and execution
  logic        busy, done, supported, launch_req, launch;
  logic [31:0] dec_word;
  hart_op_t    dec_op, cur_op;

  assign launch_req = (reg_wr && is_cmd) || auto_hit;
  assign dec_word   = (reg_wr && is_cmd) ? reg_wdata : cmd_q;
  assign launch     = launch_req && !busy && (err_q == ERR_NONE) && supported;

  dbg_cmd_decode #(.MAX_SIZE(MAX_SIZE)) u_decode (
    .cmd(dec_word), .supported(supported), .op(dec_op)
  );

  dbg_cmd_exec u_exec (
    .clk(clk), .rst_n(rst_n), .launch(launch), .op_in(dec_op),
    .busy(busy), .req_valid(hart_req_valid), .req_ready(hart_req_ready),
    .op_out(cur_op), .rsp_valid(hart_rsp_valid), .done(done)
  );

  assign hart_regno    = cur_op.regno;
  assign hart_size     = cur_op.size;
  assign hart_postexec = cur_op.postexec;
  assign hart_transfer = cur_op.transfer;
  assign hart_write    = cur_op.write;
  assign hart_arg      = data_q[0];

  // error field: first error sticks, cleared bitwise by write-one
  logic [2:0] rsp_err;
  always_comb begin
    case (hart_rsp_code)
      2'd1:    rsp_err = ERR_EXC;
      2'd2:    rsp_err = ERR_STATE;
      2'd3:    rsp_err = ERR_OTHER;
      default: rsp_err = ERR_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= ERR_NONE;
    end else if (err_q == ERR_NONE) begin
      if (busy && ((reg_wr && is_cmd) || (access && data_hit)))
        err_q <= ERR_BUSY;
      else if (done)
        err_q <= rsp_err;
      else if (launch_req && !busy && !supported)
        err_q <= ERR_UNSUP;
    end else if (reg_wr && is_stat) begin
      err_q <= err_q & ~reg_wdata[10:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      mask_q <= '0;
    end else begin
      if (reg_wr && is_cmd && !busy && err_q == ERR_NONE) cmd_q <= reg_wdata;
      if (reg_wr && is_auto) mask_q <= reg_wdata & MASK_VALID;
    end
  end

  for (genvar i = 0; i < DATA_N; i++) begin : g_data
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[i] <= '0;
      end else if (reg_wr && data_sel[i] && !busy) begin
        data_q[i] <= reg_wdata;
      end else if (i == 0 && done && hart_rsp_code == 2'd0 &&
                   cur_op.transfer && !cur_op.write) begin
        data_q[i] <= hart_rsp_data;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (is_stat) begin
      reg_rdata[28:24] = 5'(PROG_N);
      reg_rdata[12]    = busy;
      reg_rdata[10:8]  = err_q;
      reg_rdata[3:0]   = 4'(DATA_N);
    end else if (is_cmd) begin
      reg_rdata = cmd_q;
    end else if (is_auto) begin
      reg_rdata = mask_q;
    end else begin
      for (int i = 0; i < DATA_N; i++)
        if (data_sel[i]) reg_rdata = data_q[i];
    end
  end

  // R4: busy never starts while an error is latched
  a_r4_no_start_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(err_q) == ERR_NONE);
  // R3: command write while busy flags a conflict
  a_r3_busy_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && is_cmd && busy && err_q == ERR_NONE |=> err_q == ERR_BUSY);
  // R5: a latched error only changes through a status write
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q != ERR_NONE && !(reg_wr && is_stat) |=> err_q == $past(err_q));
  // R7: an unsupported command never reaches the hart
  a_r7_unsup_idle: assert property (@(posedge clk) disable iff (!rst_n)
    launch_req && !busy && err_q == ERR_NONE && !supported |=> !busy);
endmodule

// File: tb/dbg_cmd_seq_bench.sv
module dbg_cmd_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_N = 2, PROG_N = 8, MAX_SIZE = 3;

  logic clk = 0, rst_n = 0;
  logic [6:0] reg_addr = '0;
  logic reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic hart_req_valid, hart_req_ready = 0;
  logic [15:0] hart_regno;
  logic [2:0] hart_size;
  logic hart_postexec, hart_transfer, hart_write;
  logic [31:0] hart_arg;
  logic hart_rsp_valid = 0;
  logic [1:0] hart_rsp_code = 0;
  logic [31:0] hart_rsp_data = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_cmd_seq #(.DATA_N(DATA_N), .PROG_N(PROG_N), .MAX_SIZE(MAX_SIZE)) u_dbg_cmd_seq (
    .clk, .rst_n, .reg_addr, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata,
    .hart_req_valid, .hart_req_ready, .hart_regno, .hart_size, .hart_postexec,
    .hart_transfer, .hart_write, .hart_arg, .hart_rsp_valid, .hart_rsp_code,
    .hart_rsp_data);

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat(logic b, logic [2:0] e);
    logic [31:0] s = '0;
    s[28:24] = 5'(PROG_N); s[12] = b; s[10:8] = e; s[3:0] = 4'(DATA_N);
    return s;
  endfunction
  function automatic logic [31:0] hart_val(logic [15:0] r);
    return {r, ~r};
  endfunction
  function automatic logic [2:0] code_err(logic [1:0] c);
    case (c) 2'd1: return 3'd3; 2'd2: return 3'd4; 2'd3: return 3'd7; default: return 3'd0; endcase
  endfunction
  function automatic logic [31:0] mk_cmd(logic [7:0] k, logic [2:0] sz, logic pe,
                                         logic tr, logic wr, logic [15:0] rn);
    return {k, 1'b0, sz, 1'b0, pe, tr, wr, rn};
  endfunction

  // hart model
  int hart_lat = 2;
  logic [1:0] hart_next_code = 0;
  int req_cnt = 0;
  logic [15:0] cap_regno; logic [2:0] cap_size;
  logic cap_pe, cap_tr, cap_wr; logic [31:0] cap_arg;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && hart_req_valid) begin
        hart_req_ready = 1;
        cap_regno = hart_regno; cap_size = hart_size; cap_pe = hart_postexec;
        cap_tr = hart_transfer; cap_wr = hart_write; cap_arg = hart_arg;
        req_cnt++;
        @(negedge clk); hart_req_ready = 0;
        repeat (hart_lat) @(negedge clk);
        hart_rsp_valid = 1; hart_rsp_code = hart_next_code;
        hart_rsp_data = hart_val(cap_regno);
        @(negedge clk); hart_rsp_valid = 0;
      end
    end
  end

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1; reg_rd = 0;
    @(posedge clk); #1 reg_wr = 0;
  endtask
  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; reg_wr = 0;
    #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask
  task automatic wait_idle();
    logic [31:0] s;
    for (int n = 0; n < 200; n++) begin
      rd(7'h16, s);
      if (!s[12]) return;
    end
  endtask
  task automatic clr_err(); wr(7'h16, 32'h700); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++; vectors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1, R11: reset state and status layout
    rd(7'h16, v); chk("R1/R11 status after reset", v, exp_stat(0, 0));
    rd(7'h04, v); chk("R1 data0 after reset", v, 0);
    rd(7'h18, v); chk("R1 mask after reset", v, 0);
    chk("R1 no request", {31'b0, hart_req_valid}, 0);

    // R2, R6, R9: register read transfer
    hart_lat = 3; hart_next_code = 0;
    wr(7'h17, mk_cmd(0, 2, 1, 1, 0, 16'h1001));
    rd(7'h16, v); chk("R2 busy after command", v, exp_stat(1, 0));
    wait_idle();
    chk("R6 regno", cap_regno, 16'h1001);
    chk("R6 size/postexec/transfer/write", {cap_size, cap_pe, cap_tr, cap_wr}, {3'd2, 1'b1, 1'b1, 1'b0});
    rd(7'h04, v); chk("R9 read transfer into data0", v, hart_val(16'h1001));

    // R9: write transfer presents data0
    wr(7'h04, 32'hCAFE_0001);
    wr(7'h17, mk_cmd(0, 3, 0, 1, 1, 16'h0302));
    wait_idle();
    chk("R9 write transfer arg", cap_arg, 32'hCAFE_0001);
    rd(7'h04, v); chk("R9 data0 kept on write", v, 32'hCAFE_0001);

    // R3: conflicts while busy
    hart_lat = 6;
    wr(7'h17, mk_cmd(0, 2, 0, 1, 1, 16'h0005));
    wr(7'h17, mk_cmd(0, 2, 0, 1, 1, 16'h0006));
    rd(7'h16, v); chk("R3 command while busy", v, exp_stat(1, 1));
    wait_idle(); clr_err();
    wr(7'h17, mk_cmd(0, 2, 0, 1, 1, 16'h0007));
    wr(7'h05, 32'h1234_5678);
    wait_idle();
    rd(7'h16, v); chk("R3 data write while busy", v, exp_stat(0, 1));
    rd(7'h05, v); chk("R3 data1 unchanged", v, 0);

    // R4: refused while error pending
    base = req_cnt;
    wr(7'h17, mk_cmd(0, 2, 0, 1, 0, 16'h0008));
    rd(7'h16, v); chk("R4 no busy while error", v, exp_stat(0, 1));
    repeat (4) @(negedge clk);
    chk("R4 no request while error", req_cnt, base);

    // R5: bitwise write-one clear
    clr_err();
    hart_lat = 1; hart_next_code = 1;
    wr(7'h17, mk_cmd(0, 2, 0, 1, 0, 16'h0009)); wait_idle();
    rd(7'h16, v); chk("R10 exception -> 3", v, exp_stat(0, 3));
    wr(7'h16, 32'h100);
    rd(7'h16, v); chk("R5 partial clear", v, exp_stat(0, 2));
    wr(7'h16, 32'h000);
    rd(7'h16, v); chk("R5 zero write keeps", v, exp_stat(0, 2));
    wr(7'h16, 32'h200);
    rd(7'h16, v); chk("R5 full clear", v, exp_stat(0, 0));

    // R10: other response codes
    hart_next_code = 2;
    wr(7'h17, mk_cmd(0, 2, 0, 1, 0, 16'h000A)); wait_idle();
    rd(7'h16, v); chk("R10 wrong state -> 4", v, exp_stat(0, 4)); clr_err();
    hart_next_code = 3;
    wr(7'h17, mk_cmd(0, 2, 0, 1, 0, 16'h000B)); wait_idle();
    rd(7'h16, v); chk("R10 other -> 7", v, exp_stat(0, 7)); clr_err();
    hart_next_code = 0;

    // R7, R8: unsupported
    base = req_cnt;
    wr(7'h17, mk_cmd(1, 2, 0, 1, 0, 16'h0001));
    rd(7'h16, v); chk("R7 unknown type", v, exp_stat(0, 2)); clr_err();
    wr(7'h17, mk_cmd(0, 1, 0, 1, 0, 16'h0001));
    rd(7'h16, v); chk("R7 size 1", v, exp_stat(0, 2)); clr_err();
    wr(7'h17, mk_cmd(0, 4, 0, 1, 0, 16'h0001));
    rd(7'h16, v); chk("R8 size above max", v, exp_stat(0, 2)); clr_err();
    repeat (4) @(negedge clk);
    chk("R7 no request for unsupported", req_cnt, base);

    // R12: auto-execute
    wr(7'h17, mk_cmd(0, 2, 0, 1, 0, 16'h00C0)); wait_idle();
    wr(7'h18, 32'hFFFF_FFFF);
    rd(7'h18, v); chk("R12 mask valid bits", v, 32'h00FF_0003);
    wr(7'h18, 32'h0001_0002);
    base = req_cnt;
    rd(7'h05, v); wait_idle();
    chk("R12 marked data read reruns", req_cnt, base + 1);
    wr(7'h20, 32'h0); wait_idle();
    chk("R12 marked progbuf write reruns", req_cnt, base + 2);
    rd(7'h04, v); wr(7'h21, 0); repeat (4) @(negedge clk);
    chk("R12 unmarked words do not rerun", req_cnt, base + 2);

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [15:0] rn; logic w; logic [1:0] c; logic [31:0] dv;
      rn = 16'($urandom); w = 1'($urandom); dv = $urandom;
      c = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
      hart_lat = $urandom_range(0, 4); hart_next_code = c;
      wr(7'h04, dv);
      wr(7'h17, mk_cmd(0, 2, 0, 1, w, rn));
      wait_idle();
      chk("R6 random regno", cap_regno, rn);
      rd(7'h16, v); chk("R10 random status", v, exp_stat(0, code_err(c)));
      rd(7'h04, v);
      chk("R9 random data0", v, (c == 0 && !w) ? hart_val(rn) : dv);
      clr_err();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule